// File: doc/BRIEF.md
# Transmit Attempt and Check-Sequence Controller

This block decides how many times a single outgoing frame is tried on a shared medium, how long the transmitter waits after each collision, and whether a frame check sequence goes on the end of the frame. The MAC transmit path asks for a frame with `frame_req`. The block then issues `attempt_start` pulses. It listens for `mac_coll` or `mac_done` during each attempt, and it reports the end of the frame with a one-cycle `tx_ok` or `retry_error` pulse.

The mode bits are held in a small register that takes a write only while the controller is halted (`ctl_stopped` high). These bits select:
- single-attempt operation (`cfg_dis_retry`),
- a collision test path (`cfg_force_coll`, which acts only together with `cfg_int_loop`),
- suppression of the check sequence (`cfg_dis_fcs`).

A flag sent with each frame (`frame_add_fcs`) can ask for the check sequence even when it is globally suppressed. While retransmission is possible, `protect_head` tells the buffer logic to keep the first 64 bytes of the frame.

Top module: `tx_retry_ctl`

## Requirements
- R1: With retry enabled, a frame gets at most MAX_ATTEMPTS (16) attempts. The collision on the 16th attempt produces a `retry_error` pulse, no further `attempt_start` follows, and `attempt_cnt` reads 15 in the pulse cycle.
- R2: With the disable-retry mode bit set, only one attempt is made, and its collision produces `retry_error`.
- R3: `protect_head` is high from the cycle after frame acceptance until the result cycle, but only while retry is enabled. In single-attempt mode it stays low.
- R4: When force-collision and internal loopback are both set, every attempt collides in its first active cycle, even if `mac_done` is high. The frame ends in `retry_error`.
- R5: When internal loopback is clear, force-collision has no effect, and a `mac_done` ends the frame with `tx_ok`.
- R6: `append_fcs` = NOT(disable-FCS mode bit) OR (the `frame_add_fcs` value latched when the frame is accepted).
- R7: A mode write (`cfg_wr`) takes effect at the next clock edge only if `ctl_stopped` is high. Otherwise it is ignored.
- R8: After collision number n, `bo_slots` holds a value in 0 to 2^min(n,10)-1. `attempt_start` is then high exactly `bo_slots`*SLOT_CYCLES+2 cycles after the cycle in which `mac_coll` was high.
- R9: `tx_ok` and `retry_error` are single-cycle pulses, never high together, and appear in the cycle after the one in which the result was sampled. `attempt_cnt` counts the collisions of the current frame and clears when a frame is accepted.
- R10: A `frame_req` is accepted only when `busy` is low. Requests while busy are ignored. A collision sampled together with `mac_done` counts as a collision.
- R11: After reset, all mode bits are 0, `busy`, `attempt_start`, `tx_ok`, `retry_error` and `protect_head` are 0, `attempt_cnt` is 0, and `append_fcs` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_stopped | input | 1 | Controller halted; mode writes allowed |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_dis_retry | input | 1 | Single-attempt mode |
| cfg_force_coll | input | 1 | Force collision test path |
| cfg_int_loop | input | 1 | Internal loopback active |
| cfg_dis_fcs | input | 1 | Suppress check sequence globally |
| frame_req | input | 1 | New frame ready to send |
| frame_add_fcs | input | 1 | Per-frame request for a check sequence |
| mac_coll | input | 1 | Collision seen during the current attempt |
| mac_done | input | 1 | Current attempt finished cleanly |
| attempt_start | output | 1 | Start one transmission attempt |
| busy | output | 1 | A frame is in progress |
| protect_head | output | 1 | Keep the frame head for a retransmission |
| append_fcs | output | 1 | Append a check sequence to this frame |
| tx_ok | output | 1 | Frame sent (pulse) |
| retry_error | output | 1 | Attempt limit reached (pulse) |
| attempt_cnt | output | CNT_W | Collisions so far in this frame |
| bo_slots | output | BACKOFF_CAP | Last drawn backoff, in slot times |

## Verification
Each result has a fixed latency:
- An accepted `frame_req` produces `attempt_start` in the following cycle.
- A collision or done sampled at an edge shows `tx_ok`, `retry_error` and the new `attempt_cnt` in the cycle after that edge.
- A backoff of W cycles delays the next `attempt_start` by W+2 cycles from the collision cycle.

The bench keeps a behavioural model that advances at each rising edge and compares every output at the falling edge. It takes the random backoff draw from `bo_slots` one cycle after the collision, checks its range, and uses it to predict the exact restart cycle.

// File: rtl/tx_retry_ctl.sv
module tx_retry_ctl #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  parameter int SLOT_CYCLES  = 4,
  localparam int CNT_W  = $clog2(MAX_ATTEMPTS),
  localparam int BO_W   = BACKOFF_CAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_stopped,
  input  logic             cfg_wr,
  input  logic             cfg_dis_retry,
  input  logic             cfg_force_coll,
  input  logic             cfg_int_loop,
  input  logic             cfg_dis_fcs,
  input  logic             frame_req,
  input  logic             frame_add_fcs,
  input  logic             mac_coll,
  input  logic             mac_done,
  output logic             attempt_start,
  output logic             busy,
  output logic             protect_head,
  output logic             append_fcs,
  output logic             tx_ok,
  output logic             retry_error,
  output logic [CNT_W-1:0] attempt_cnt,
  output logic [BO_W-1:0]  bo_slots
);

  localparam int WAIT_W = BO_W + $clog2(SLOT_CYCLES + 1);
  localparam int K_W    = $clog2(BO_W + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_ACTIVE, S_BACKOFF} st_t;

  st_t              st;
  logic             dis_retry, force_coll, int_loop, dis_fcs, frm_fcs;
  logic [15:0]      lfsr;
  logic [WAIT_W-1:0] wait_q;

  // mode register, writable only while halted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_retry  <= 1'b0;
      force_coll <= 1'b0;
      int_loop   <= 1'b0;
      dis_fcs    <= 1'b0;
    end else if (cfg_wr && ctl_stopped) begin
      dis_retry  <= cfg_dis_retry;
      force_coll <= cfg_force_coll;
      int_loop   <= cfg_int_loop;
      dis_fcs    <= cfg_dis_fcs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  logic             coll_eff, last_try;
  logic [K_W-1:0]   k_exp;
  logic [BO_W-1:0]  bo_mask, bo_draw;
  logic [CNT_W:0]   cnt_inc;

  assign coll_eff = mac_coll | (force_coll & int_loop);
  assign last_try = dis_retry ? (attempt_cnt == '0)
                              : (attempt_cnt == CNT_W'(MAX_ATTEMPTS - 1));
  assign cnt_inc  = {1'b0, attempt_cnt} + 1'b1;
  assign k_exp    = (cnt_inc > (CNT_W+1)'(BACKOFF_CAP)) ? K_W'(BACKOFF_CAP) : K_W'(cnt_inc);
  assign bo_mask  = {BO_W{1'b1}} >> (K_W'(BO_W) - k_exp);
  assign bo_draw  = lfsr[BO_W-1:0] & bo_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      attempt_cnt <= '0;
      bo_slots    <= '0;
      wait_q      <= '0;
      frm_fcs     <= 1'b0;
      tx_ok       <= 1'b0;
      retry_error <= 1'b0;
    end else begin
      tx_ok       <= 1'b0;
      retry_error <= 1'b0;
      case (st)
        S_IDLE: if (frame_req) begin
          st          <= S_START;
          attempt_cnt <= '0;
          frm_fcs     <= frame_add_fcs;
        end
        S_START: st <= S_ACTIVE;
        S_ACTIVE: begin
          if (coll_eff) begin
            if (last_try) begin
              retry_error <= 1'b1;
              st          <= S_IDLE;
            end else begin
              attempt_cnt <= attempt_cnt + 1'b1;
              bo_slots    <= bo_draw;
              wait_q      <= WAIT_W'(bo_draw) * WAIT_W'(SLOT_CYCLES);
              st          <= S_BACKOFF;
            end
          end else if (mac_done) begin
            tx_ok <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_BACKOFF: begin
          if (wait_q == '0) st <= S_START;
          else              wait_q <= wait_q - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign attempt_start = (st == S_START);
  assign busy          = (st != S_IDLE);
  assign protect_head  = busy & ~dis_retry;
  assign append_fcs    = ~dis_fcs | frm_fcs;

  assert_err_at_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    retry_error |-> (attempt_cnt == ($past(dis_retry) ? '0 : CNT_W'(MAX_ATTEMPTS - 1))));

  assert_forced_never_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_coll && int_loop) |-> !tx_ok);

  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_stopped |=> $stable({dis_retry, force_coll, int_loop, dis_fcs}));

  assert_backoff_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BACKOFF && $past(st) == S_ACTIVE) |->
      ((bo_slots & ~({BO_W{1'b1}} >> (BO_W -
        ((attempt_cnt > CNT_W'(BACKOFF_CAP)) ? BACKOFF_CAP : int'(attempt_cnt))))) == '0));

  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ok && retry_error));

  assert_ok_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> !tx_ok);

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_start |=> !attempt_start);

endmodule

// File: tb/tx_retry_ctl_tb.sv
module tx_retry_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 4;

  logic clk = 0, rst_n = 0;
  logic ctl_stopped = 0, cfg_wr = 0, cfg_dis_retry = 0, cfg_force_coll = 0, cfg_int_loop = 0, cfg_dis_fcs = 0;
  logic frame_req = 0, frame_add_fcs = 0, mac_coll = 0, mac_done = 0;
  logic attempt_start, busy, protect_head, append_fcs, tx_ok, retry_error;
  logic [3:0] attempt_cnt;
  logic [9:0] bo_slots;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_retry_ctl #(.MAX_ATTEMPTS(16), .BACKOFF_CAP(10), .SLOT_CYCLES(SLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_stopped(ctl_stopped), .cfg_wr(cfg_wr),
    .cfg_dis_retry(cfg_dis_retry), .cfg_force_coll(cfg_force_coll), .cfg_int_loop(cfg_int_loop),
    .cfg_dis_fcs(cfg_dis_fcs), .frame_req(frame_req), .frame_add_fcs(frame_add_fcs),
    .mac_coll(mac_coll), .mac_done(mac_done), .attempt_start(attempt_start), .busy(busy),
    .protect_head(protect_head), .append_fcs(append_fcs), .tx_ok(tx_ok),
    .retry_error(retry_error), .attempt_cnt(attempt_cnt), .bo_slots(bo_slots));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_ph = 0, m_cnt = 0, m_wait = 0;
  bit m_ok = 0, m_err = 0, m_dr = 0, m_fc = 0, m_il = 0, m_df = 0, m_addf = 0, m_need = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_wait = 0; m_ok = 0; m_err = 0;
      m_dr = 0; m_fc = 0; m_il = 0; m_df = 0; m_addf = 0; m_need = 0;
    end else begin
      m_ok = 0; m_err = 0;
      case (m_ph)
        0: if (frame_req) begin m_ph = 1; m_cnt = 0; m_addf = frame_add_fcs; end
        1: m_ph = 2;
        2: if (mac_coll || (m_fc && m_il)) begin
             if (m_cnt == (m_dr ? 0 : 15)) begin m_err = 1; m_ph = 0; end
             else begin m_cnt++; m_ph = 3; m_need = 1; end
           end else if (mac_done) begin m_ok = 1; m_ph = 0; end
        3: if (m_wait == 0) m_ph = 1; else m_wait--;
        default: m_ph = 0;
      endcase
      if (cfg_wr && ctl_stopped) begin
        m_dr = cfg_dis_retry; m_fc = cfg_force_coll; m_il = cfg_int_loop; m_df = cfg_dis_fcs;
      end
    end
  end

  int starts = 0;
  bit saw_protect = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_need) begin
        int k;
        k = (m_cnt > 10) ? 10 : m_cnt;
        chk("R8", "bo_slots range", (int'(bo_slots) < (1 << k)), 1);
        m_wait = int'(bo_slots) * SLOT;
        m_need = 0;
      end
      chk("R8", "attempt_start", attempt_start, m_ph == 1);
      chk("R10", "busy", busy, m_ph != 0);
      chk("R9", "tx_ok", tx_ok, m_ok);
      chk("R1", "retry_error", retry_error, m_err);
      chk("R9", "attempt_cnt", attempt_cnt, m_cnt);
      chk("R3", "protect_head", protect_head, (m_ph != 0) && !m_dr);
      chk("R6", "append_fcs", append_fcs, !m_df || m_addf);
      if (attempt_start) starts++;
      if (protect_head) saw_protect = 1;
    end
  end

  task automatic set_mode(input bit stopped, input bit dr, input bit fc, input bit il, input bit df);
    ctl_stopped = stopped; cfg_wr = 1;
    cfg_dis_retry = dr; cfg_force_coll = fc; cfg_int_loop = il; cfg_dis_fcs = df;
    @(negedge clk);
    cfg_wr = 0; ctl_stopped = 0;
    @(negedge clk);
  endtask

  // drives ncoll collisions then done; returns 1 for tx_ok, 2 for retry_error
  task automatic run_frame(input bit addf, input int ncoll, input bit req_busy, output int result);
    bit fin = 0;
    int tries = 0;
    starts = 0; saw_protect = 0; result = 0;
    frame_req = 1; frame_add_fcs = addf;
    @(negedge clk);
    frame_req = 0;
    while (!fin) begin
      if (attempt_start) begin
        tries++;
        @(negedge clk);
        if (tries <= ncoll) mac_coll = 1; else mac_done = 1;
        if (req_busy) begin frame_req = 1; frame_add_fcs = !addf; end
        @(negedge clk);
        mac_coll = 0; mac_done = 0; frame_req = 0;
        if (tx_ok) begin result = 1; fin = 1; end
        if (retry_error) begin result = 2; fin = 1; end
      end else @(negedge clk);
    end
    @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int res;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "protect after reset", protect_head, 0);
    chk("R11", "append after reset", append_fcs, 1);
    chk("R11", "cnt after reset", attempt_cnt, 0);

    run_frame(0, 0, 0, res);
    chk("R9", "clean frame result", res, 1);
    chk("R9", "clean frame starts", starts, 1);

    run_frame(0, 3, 0, res);
    chk("R8", "three collisions result", res, 1);
    chk("R8", "three collisions starts", starts, 4);
    chk("R9", "cnt held after ok", attempt_cnt, 3);

    run_frame(1, 40, 0, res);
    chk("R1", "limit result", res, 2);
    chk("R1", "limit starts", starts, 16);
    chk("R3", "protect seen in retry mode", saw_protect, 1);

    set_mode(1, 1, 0, 0, 1);
    run_frame(0, 5, 0, res);
    chk("R2", "single attempt result", res, 2);
    chk("R2", "single attempt starts", starts, 1);
    chk("R3", "no protect single", saw_protect, 0);
    chk("R6", "fcs off", append_fcs, 0);
    run_frame(1, 0, 0, res);
    chk("R6", "per-frame fcs", append_fcs, 1);

    set_mode(0, 0, 0, 0, 0);
    run_frame(0, 0, 0, res);
    chk("R7", "write ignored when running", saw_protect, 0);
    chk("R7", "fcs still off", append_fcs, 0);

    set_mode(1, 0, 1, 0, 0);
    run_frame(0, 0, 0, res);
    chk("R5", "force without loop", res, 1);
    chk("R5", "force without loop starts", starts, 1);

    set_mode(1, 0, 1, 1, 0);
    run_frame(0, 0, 0, res);
    chk("R4", "forced collision result", res, 2);
    chk("R4", "forced collision starts", starts, 16);

    set_mode(1, 0, 0, 0, 0);
    run_frame(0, 2, 1, res);
    chk("R10", "busy request ignored result", res, 1);
    chk("R10", "busy request ignored starts", starts, 3);
    chk("R10", "cnt not cleared by busy req", attempt_cnt, 2);
    repeat (3) @(negedge clk);
    chk("R10", "no stray frame", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule